// File: doc/BRIEF.md
# Serial-bus LED dimmer register interface

This block is a two-wire serial bus (I2C) slave that gives a bus master access to a small bank of byte registers. These registers set up two blink generators and per-output drive modes. The block oversamples SCL and SDA with the system clock, finds START and STOP conditions and matches the 7-bit device address. After a write address, the first data byte loads a register pointer, and each later byte is stored at that pointer. A read address makes the block shift out the byte at the pointer, MSB first. When the auto-advance flag is set, the pointer steps after every data byte.

The bank holds ten slots. Slots 0 and 1 show the live levels of sixteen pins and cannot be written. Slots 2 to 9 are writable and drive the block's configuration outputs. Slots 10 to 15 are unused. The block acknowledges them like any other slot: writes to them change nothing and reads from them return zero. SDA is driven only as an open-drain pull-low request.

Top module: `i2c_led_regif`

## Requirements
- R1: The device answers only the address byte whose bits 7:4 are 1100 and whose bits 3:1 equal `dev_pins`. It pulls SDA low in the acknowledge slot. Any other address gets no acknowledge, and every byte up to the next START is ignored.
- R2: In a write transfer, the byte after the address is a pointer byte. Bits 3:0 give the slot index, bit 4 is the auto-advance flag and bits 7:5 are ignored. The pointer byte is acknowledged.
- R3: Each later byte of a write transfer is acknowledged and stored in the slot at the pointer. Slot 2 drives `div_a`, 3 drives `duty_a`, 4 drives `div_b` and 5 drives `duty_b`. Slots 6 to 9 drive `led_mode[7:0]`, `[15:8]`, `[23:16]` and `[31:24]`.
- R4: With the auto-advance flag set, the index moves forward by one after each data byte written or loaded for reading. It goes from 9 to 0 and from 15 to 0. With the flag clear the index stays fixed.
- R5: Bytes written to slots 0 and 1 are acknowledged and change no output.
- R6: Slots 10 to 15 acknowledge writes and ignore them, and they read as 00h.
- R7: After an address with bit 0 set, the block shifts out the byte at the pointer, MSB first. Slot 0 reads `pins[7:0]`, slot 1 reads `pins[15:8]`, and slots 2 to 9 read back their stored values.
- R8: A byte for reading is taken at the SCL falling edge that ends the acknowledge slot just before it. Later pin changes do not alter that byte.
- R9: If the master does not acknowledge a read byte, the block releases SDA and drives nothing more until a new START.
- R10: Reset sets `div_a`, `div_b` and `led_mode` to 0, sets `duty_a` and `duty_b` to 80h and clears the pointer.
- R11: A STOP releases SDA and returns the block to idle. A repeated START begins a new address phase and keeps the pointer.
- R12: The block changes `sda_pull_low` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| dev_pins | input | 3 | Board-strapped low address bits |
| pins | input | 16 | Live pin levels read through slots 0 and 1 |
| sda_pull_low | output | 1 | High requests the open-drain SDA driver to pull low |
| div_a | output | 8 | Period setting for blink generator A |
| duty_a | output | 8 | Duty setting for blink generator A |
| div_b | output | 8 | Period setting for blink generator B |
| duty_b | output | 8 | Duty setting for blink generator B |
| led_mode | output | 32 | Two mode bits per output, output k at bits 2k+1:2k |

## Verification
A wrong pointer, either from a missed advance or a bad wrap, shows up at the ports within one byte time. The byte after it lands in the wrong configuration output, or a read returns a neighbour's value. A wrong bus state shows up as a missing or extra acknowledge pulse in the next ninth clock slot. It can also show up as SDA still pulled after a NACK or a STOP, which the bench watches on every clock. Pin-capture timing is checked by changing the pins in the middle of a byte and comparing both the captured value and the one that follows.

// File: rtl/ledif_pkg.sv
package ledif_pkg;

    localparam int IDX_W  = 4;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } bus_state_e;

    typedef struct packed {
        logic             ai;
        logic [IDX_W-1:0] idx;
    } cmd_ptr_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } line_ev_t;

    function automatic logic [IDX_W-1:0] ptr_next(logic [IDX_W-1:0] idx,
                                                  logic [IDX_W-1:0] last);
        if (idx == last || idx == '1) return '0;
        return idx + 1'b1;
    endfunction

    function automatic logic [BYTE_W-1:0] slot_reset_val(int slot);
        return (slot == 3 || slot == 5) ? 8'h80 : 8'h00;
    endfunction

endpackage

// File: rtl/ledif_line_sync.sv
module ledif_line_sync
    import ledif_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh[g] <= 1'b1;
                    sda_sh[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_sh[g] <= scl_i;
                    sda_sh[g] <= sda_i;
                end else begin
                    scl_sh[g] <= scl_sh[(g == 0) ? 0 : g-1];
                    sda_sh[g] <= sda_sh[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_sh[STAGES-1];
            sda_d <= sda_sh[STAGES-1];
        end
    end

    always_comb begin
        ev.scl   = scl_sh[STAGES-1];
        ev.sda   = sda_sh[STAGES-1];
        ev.rise  = ev.scl & ~scl_d;
        ev.fall  = ~ev.scl & scl_d;
        ev.start = ev.scl & scl_d & sda_d & ~ev.sda;
        ev.stop  = ev.scl & scl_d & ~sda_d & ev.sda;
    end
endmodule

// File: rtl/ledif_bus_fsm.sv
module ledif_bus_fsm
    import ledif_pkg::*;
#(
    parameter logic [3:0]       DEV_ID   = 4'b1100,
    parameter logic [IDX_W-1:0] LAST_IDX = 4'd9
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic [2:0]        dev_pins,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              ptr_adv,
    output logic              sda_pull
);
    bus_state_e        state;
    cmd_ptr_t          ptr;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] rx, tx;
    logic              rw, m_ack;

    assign rd_idx = ptr.idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            bitcnt   <= '0;
            rx       <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            m_ack    <= 1'b0;
            wr_stb   <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            ptr_adv  <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            wr_stb  <= 1'b0;
            ptr_adv <= 1'b0;
            if (ev.stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else if (ev.start) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (ev.rise) begin
                            rx     <= {rx[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                if (rx[7:1] == {DEV_ID, dev_pins}) begin
                                    rw       <= rx[0];
                                    sda_pull <= 1'b1;
                                    state    <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_CMD) begin
                                ptr      <= rx[IDX_W:0];
                                sda_pull <= 1'b1;
                                state    <= ST_CMD_ACK;
                            end else begin
                                wr_stb   <= 1'b1;
                                wr_idx   <= ptr.idx;
                                wr_data  <= rx;
                                if (ptr.ai) ptr.idx <= ptr_next(ptr.idx, LAST_IDX);
                                ptr_adv  <= ptr.ai;
                                sda_pull <= 1'b1;
                                state    <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.fall) begin
                            if (rw) begin
                                tx       <= rd_data;
                                sda_pull <= ~rd_data[BYTE_W-1];
                                bitcnt   <= '0;
                                if (ptr.ai) ptr.idx <= ptr_next(ptr.idx, LAST_IDX);
                                ptr_adv  <= ptr.ai;
                                state    <= ST_RDATA;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_CMD;
                            end
                        end
                    end
                    ST_CMD_ACK, ST_WDATA_ACK: begin
                        if (ev.fall) begin
                            sda_pull <= 1'b0;
                            state    <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_pull <= 1'b0;
                                bitcnt   <= '0;
                                state    <= ST_RACK;
                            end else begin
                                tx       <= {tx[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~tx[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.rise) begin
                            m_ack <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (m_ack) begin
                                tx       <= rd_data;
                                sda_pull <= ~rd_data[BYTE_W-1];
                                if (ptr.ai) ptr.idx <= ptr_next(ptr.idx, LAST_IDX);
                                ptr_adv  <= ptr.ai;
                                state    <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ledif_reg_bank.sv
module ledif_reg_bank
    import ledif_pkg::*;
#(
    parameter int SLOTS    = 10,
    parameter int FIRST_RW = 2,
    localparam int RW_CNT  = SLOTS - FIRST_RW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_stb,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    input  logic [2*BYTE_W-1:0]      pins,
    output logic [BYTE_W-1:0]        rd_data,
    output logic [RW_CNT*BYTE_W-1:0] rw_flat
);
    logic [BYTE_W-1:0] store [FIRST_RW:SLOTS-1];

    genvar g;
    generate
        for (g = FIRST_RW; g < SLOTS; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    store[g] <= slot_reset_val(g);
                else if (wr_stb && wr_idx == IDX_W'(g))
                    store[g] <= wr_data;
            end
            assign rw_flat[(g-FIRST_RW)*BYTE_W +: BYTE_W] = store[g];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_idx == IDX_W'(0)) rd_data = pins[BYTE_W-1:0];
        if (rd_idx == IDX_W'(1)) rd_data = pins[2*BYTE_W-1:BYTE_W];
        for (int k = FIRST_RW; k < SLOTS; k++)
            if (rd_idx == IDX_W'(k)) rd_data = store[k];
    end
endmodule

// File: rtl/i2c_led_regif.sv
module i2c_led_regif
    import ledif_pkg::*;
#(
    parameter logic [3:0] DEV_ID      = 4'b1100,
    parameter int          SYNC_STAGES = 2,
    parameter int          SLOTS       = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [2:0]  dev_pins,
    input  logic [15:0] pins,
    output logic        sda_pull_low,
    output logic [7:0]  div_a,
    output logic [7:0]  duty_a,
    output logic [7:0]  div_b,
    output logic [7:0]  duty_b,
    output logic [31:0] led_mode
);
    localparam int               FIRST_RW = 2;
    localparam int               RW_CNT   = SLOTS - FIRST_RW;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

    line_ev_t                 ev;
    logic [BYTE_W-1:0]        rd_data, wr_data;
    logic [IDX_W-1:0]         rd_idx, wr_idx;
    logic                     wr_stb, ptr_adv;
    logic [RW_CNT*BYTE_W-1:0] rw_flat;
    logic                     scl_level, stop_seen;

    ledif_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    ledif_bus_fsm #(.DEV_ID(DEV_ID), .LAST_IDX(LAST_IDX)) u_fsm (
        .clk(clk), .rst(rst), .ev(ev), .dev_pins(dev_pins),
        .rd_data(rd_data), .rd_idx(rd_idx), .wr_stb(wr_stb),
        .wr_idx(wr_idx), .wr_data(wr_data), .ptr_adv(ptr_adv),
        .sda_pull(sda_pull_low)
    );

    ledif_reg_bank #(.SLOTS(SLOTS), .FIRST_RW(FIRST_RW)) u_bank (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .pins(pins),
        .rd_data(rd_data), .rw_flat(rw_flat)
    );

    assign scl_level = ev.scl;
    assign stop_seen = ev.stop;
    assign div_a     = rw_flat[0*BYTE_W +: BYTE_W];
    assign duty_a    = rw_flat[1*BYTE_W +: BYTE_W];
    assign div_b     = rw_flat[2*BYTE_W +: BYTE_W];
    assign duty_b    = rw_flat[3*BYTE_W +: BYTE_W];
    assign led_mode  = rw_flat[4*BYTE_W +: 4*BYTE_W];
endmodule

// File: rtl/ledif_checker.sv
module ledif_checker (
    input logic        clk,
    input logic        rst,
    input logic        scl_level,
    input logic        stop_seen,
    input logic        sda_pull_low,
    input logic        wr_stb,
    input logic [3:0]  wr_idx,
    input logic        ptr_adv,
    input logic [3:0]  rd_idx,
    input logic [7:0]  div_a,
    input logic [7:0]  duty_a,
    input logic [7:0]  div_b,
    input logic [7:0]  duty_b,
    input logic [31:0] led_mode
);
    assert_reset_defaults_R10: assert property (@(posedge clk)
        rst |=> (div_a == 8'h00 && duty_a == 8'h80 && div_b == 8'h00 &&
                 duty_b == 8'h80 && led_mode == 32'h0 && rd_idx == 4'h0));

    assert_pull_only_scl_low_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_low) |-> !scl_level);

    assert_ro_slot_no_effect_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && (wr_idx < 4'd2 || wr_idx > 4'd9)) |=>
        $stable({div_a, duty_a, div_b, duty_b, led_mode}));

    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (ptr_adv && $past(rd_idx) == 4'd9) |-> rd_idx == 4'd0);

    assert_stop_releases_R11: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_pull_low);
endmodule

bind i2c_led_regif ledif_checker u_ledif_checker (
    .clk(clk), .rst(rst), .scl_level(scl_level), .stop_seen(stop_seen),
    .sda_pull_low(sda_pull_low), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .ptr_adv(ptr_adv), .rd_idx(rd_idx), .div_a(div_a), .duty_a(duty_a),
    .div_b(div_b), .duty_b(duty_b), .led_mode(led_mode)
);

// File: tb/test_i2c_led_regif.sv
module test_i2c_led_regif;
    localparam int Q = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  dev_pins = 3'b101;
    logic [15:0] pins = 16'h0000;
    logic        sda_pull_low;
    logic [7:0]  div_a, duty_a, div_b, duty_b;
    logic [31:0] led_mode;
    wire         sda_bus = sda_m & ~sda_pull_low;

    int total = 0;
    int bad = 0;
    int r12_viol = 0;
    int pull_rises = 0;
    bit finished = 0;

    logic [7:0] exp_slot [0:15];
    logic [7:0] wbuf [0:9];
    logic [7:0] rbuf [0:9];

    localparam logic [7:0] AW = 8'hCA;
    localparam logic [7:0] AR = 8'hCB;

    always #5 clk = ~clk;

    i2c_led_regif i_i2c_led_regif (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .dev_pins(dev_pins), .pins(pins), .sda_pull_low(sda_pull_low),
        .div_a(div_a), .duty_a(duty_a), .div_b(div_b), .duty_b(duty_b),
        .led_mode(led_mode)
    );

    logic prev_pull = 1'b0;
    always @(posedge clk) begin
        if (sda_pull_low !== prev_pull && scl_m === 1'b1) r12_viol++;
        if (sda_pull_low === 1'b1 && prev_pull === 1'b0) pull_rises++;
        prev_pull <= sda_pull_low;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        waitc(Q); sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(2*Q);
        sda_m = 1'b0; waitc(2*Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        waitc(Q); sda_m = 1'b0; waitc(Q); scl_m = 1'b1; waitc(2*Q);
        sda_m = 1'b1; waitc(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            waitc(Q); sda_m = b[i]; waitc(Q); scl_m = 1'b1; waitc(2*Q); scl_m = 1'b0;
        end
        waitc(Q); sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(Q);
        acked = (sda_bus == 1'b0);
        waitc(Q); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            waitc(Q); sda_m = 1'b1; waitc(Q); scl_m = 1'b1; waitc(Q);
            b[i] = sda_bus; waitc(Q); scl_m = 1'b0;
        end
        waitc(Q); sda_m = ~give_ack; waitc(Q); scl_m = 1'b1; waitc(2*Q); scl_m = 1'b0;
    endtask

    function automatic logic [3:0] nxt(logic [3:0] i);
        return (i == 4'd9 || i == 4'd15) ? 4'd0 : i + 4'd1;
    endfunction

    function automatic logic [7:0] model_read(logic [3:0] i);
        if (i == 4'd0) return pins[7:0];
        if (i == 4'd1) return pins[15:8];
        if (i >= 4'd2 && i <= 4'd9) return exp_slot[i];
        return 8'h00;
    endfunction

    task automatic check_outputs(string req);
        @(negedge clk);
        check(req, {24'h0, div_a},  {24'h0, exp_slot[2]});
        check(req, {24'h0, duty_a}, {24'h0, exp_slot[3]});
        check(req, {24'h0, div_b},  {24'h0, exp_slot[4]});
        check(req, {24'h0, duty_b}, {24'h0, exp_slot[5]});
        check(req, led_mode, {exp_slot[9], exp_slot[8], exp_slot[7], exp_slot[6]});
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) exp_slot[i] = (i == 3 || i == 5) ? 8'h80 : 8'h00;
    endtask

    // write transfer: pointer byte then n data bytes; every byte must be acknowledged
    task automatic write_regs(string req, input logic [7:0] cmd, input int n);
        bit a;
        logic [3:0] idx;
        int acks;
        idx = cmd[3:0];
        acks = 0;
        bus_start();
        send_byte(AW, a); acks += int'(a);
        send_byte(cmd, a); acks += int'(a);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a); acks += int'(a);
            if (idx >= 4'd2 && idx <= 4'd9) exp_slot[idx] = wbuf[k];
            if (cmd[4]) idx = nxt(idx);
        end
        bus_stop();
        check(req, acks, n + 2);
    endtask

    // pointer set, repeated START, read n bytes (NACK on last)
    task automatic read_regs(string req, input logic [7:0] cmd, input int n);
        bit a;
        logic [3:0] idx;
        logic [7:0] b;
        idx = cmd[3:0];
        bus_start();
        send_byte(AW, a);
        send_byte(cmd, a);
        bus_start();
        send_byte(AR, a);
        check({req, " R11 read address ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n-1, b);
            check(req, b, model_read(idx));
            if (cmd[4]) idx = nxt(idx);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        model_reset();
        check_outputs("R10 reset defaults");
        check("R10 sda released", sda_pull_low, 0);
    endtask

    task automatic t_burst_write();
        wbuf[0] = 8'h00; wbuf[1] = 8'h4D; wbuf[2] = 8'h4B; wbuf[3] = 8'h80;
        wbuf[4] = 8'h55; wbuf[5] = 8'hAA; wbuf[6] = 8'hFF; wbuf[7] = 8'h00;
        write_regs("R3 R4 burst acks", 8'h12, 8);
        check_outputs("R3 burst values");
    endtask

    task automatic t_wrong_addr();
        bit a1, a2, a3;
        int rises0;
        bus_start();
        rises0 = pull_rises;
        send_byte(8'hC0, a1);
        send_byte(8'h12, a2);
        send_byte(8'h77, a3);
        bus_stop();
        check("R1 no ack for foreign address", a1, 0);
        check("R1 later bytes ignored", {a2, a3}, 2'b00);
        check("R1 SDA never pulled", pull_rises - rises0, 0);
        check_outputs("R1 outputs unchanged");
    endtask

    task automatic t_fixed_ptr();
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        write_regs("R4 fixed pointer acks", 8'h03, 2);
        check_outputs("R4 fixed pointer overwrite");
        wbuf[0] = 8'h99;
        write_regs("R2 top bits ignored acks", 8'hE5, 1);
        check_outputs("R2 top bits ignored");
    endtask

    task automatic t_readonly();
        wbuf[0] = 8'h55; wbuf[1] = 8'h66; wbuf[2] = 8'h77;
        write_regs("R5 input slot writes acked", 8'h10, 3);
        check_outputs("R5 input slots unchanged");
    endtask

    task automatic t_high_slots();
        wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h35; wbuf[3] = 8'h56;
        write_regs("R6 slot 15 acked and wraps", 8'h1F, 4);
        check_outputs("R6 R4 slot 15 wrap to 0");
        read_regs("R6 slot 10 reads zero", 8'h0A, 1);
    endtask

    task automatic t_read_wrap();
        pins = 16'hA53C;
        read_regs("R7 R4 read 8,9,0,1", 8'h18, 4);
        read_regs("R7 read slot 3", 8'h03, 1);
    endtask

    task automatic t_capture();
        bit a;
        logic [7:0] b0, b1;
        pins = 16'h1234;
        bus_start();
        send_byte(AW, a);
        send_byte(8'h10, a);
        bus_start();
        send_byte(AR, a);
        waitc(12);
        pins = 16'hBEEF;
        recv_byte(1'b1, b0);
        waitc(12);
        pins = 16'h0000;
        recv_byte(1'b0, b1);
        bus_stop();
        check("R8 first byte taken at ack fall", b0, 8'h34);
        check("R8 second byte taken at its ack fall", b1, 8'hBE);
    endtask

    task automatic t_nack();
        bit a;
        logic [7:0] b;
        int rises0;
        bus_start();
        send_byte(AW, a);
        send_byte(8'h06, a);
        bus_start();
        send_byte(AR, a);
        recv_byte(1'b0, b);
        check("R9 byte before NACK", b, exp_slot[6]);
        rises0 = pull_rises;
        recv_byte(1'b0, b);
        check("R9 nothing driven after NACK", b, 8'hFF);
        check("R9 no pull after NACK", pull_rises - rises0, 0);
        bus_stop();
        read_regs("R9 R11 new transfer after NACK", 8'h06, 1);
    endtask

    task automatic t_midreset();
        bit a;
        bus_start();
        send_byte(AW, a);
        send_byte(8'h14, a);
        @(negedge clk); rst = 1'b1; waitc(3); rst = 1'b0;
        scl_m = 1'b1; sda_m = 1'b1; waitc(4*Q);
        t_reset();
        read_regs("R10 pointer cleared", 8'h02, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        waitc(5);
        rst = 1'b0;
        waitc(5);
        t_reset();
        t_burst_write();
        t_wrong_addr();
        t_fixed_ptr();
        t_readonly();
        t_high_slots();
        t_read_wrap();
        t_capture();
        t_nack();
        t_midreset();
        check("R12 SDA changes only while SCL low", r12_viol, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule